// File: doc/BRIEF.md
# Clock Configuration Watchdog with Recovery Reload

This block guards the configuration path of a clock synthesizer. Software arms it with an enable bit, a 3-bit period multiplier and a time-base select. If software does not service it in time, the block raises a sticky alarm flag and sends a one-cycle system reset pulse. Depending on a mode bit, it can also send a one-cycle strobe that tells the frequency-select logic to go back to a recovery setting.

Time is measured in base ticks. A base tick is a one-cycle pulse on `base_tick_i`, nominally at 1 kHz. One time unit is `SHORT_TICKS` ticks (294 by default, about 294 ms) when the scale bit is clear. It is `LONG_TICKS` ticks (2340 by default, about 2.34 s) when the scale bit is set. The timeout equals the multiplier times one unit.

Software services the watchdog by rewriting the configuration with the enable bit still set. All fields are written together through a single write strobe. The recovery-source bit is held and presented to the frequency logic. Clear means strapped hardware settings and set means the programmed recovery divider.

Top module: `clkgen_wdog`

## Requirements
- R1: A synchronous active-high `rst` clears the enable, the countdown, the alarm and every output, so all outputs read 0 after reset.
- R2: After a write with enable=1 and a nonzero multiplier M, the timeout happens on the (M × U)-th base tick that follows. U is `SHORT_TICKS` when the scale bit is 0 and `LONG_TICKS` when it is 1. The reset pulse is high during the clock cycle right after the edge that sampled that tick.
- R3: Multiplier code 000 is a test code: while it is programmed, no timeout ever occurs, however many ticks arrive.
- R4: A write with enable=1 restarts the count from the written multiplier, which services the watchdog. A write with enable=0 stops it, and no timeout follows.
- R5: The alarm flag goes to 1 together with the reset pulse. It then stays 1 until a write whose multiplier field is 000. A write with any other multiplier value leaves it set.
- R6: When the mode bit is 0, each timeout also gives a reload strobe in the same cycle as the reset pulse. When the mode bit is 1, only the reset pulse is given.
- R7: Each timeout produces exactly one single-cycle reset pulse. After it the count is halted, and further ticks produce nothing until the next enabling write.
- R8: `recov_src_o` presents the most recently written recovery-source bit: 0 selects the strapped settings and 1 selects the programmed recovery divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick_i | input | 1 | One-cycle base time tick |
| cfg_wr_i | input | 1 | Write strobe for all configuration fields |
| cfg_en_i | input | 1 | Enable field: 1 arms or services, 0 disables |
| cfg_mult_i | input | MULT_W | Period multiplier; 000 is the test code |
| cfg_scale_i | input | 1 | Time base: 0 short unit, 1 long unit |
| cfg_rst_only_i | input | 1 | Mode: 0 reset and reload, 1 reset only |
| cfg_rec_src_i | input | 1 | Recovery source: 0 strapped, 1 programmed divider |
| alarm_o | output | 1 | Sticky timeout flag |
| sys_rst_o | output | 1 | One-cycle system reset pulse |
| freq_reload_o | output | 1 | One-cycle recovery reload strobe |
| recov_src_o | output | 1 | Held recovery-source selection |

## Verification
The bench targets the exact timeout tick for both time bases, including the largest multiplier on the long base. It checks one tick before that point, where an off-by-one design would fire early or late. It services the watchdog just short of expiry, and a design that fails to reload would fire. It disables the watchdog, programs the test code, and keeps ticking after a timeout, where a design that loses track of arming would give stray or repeated pulses. It also checks that the alarm survives a nonzero rewrite, and that reload strobes are absent in reset-only mode.

// File: rtl/clkgen_wdog_pkg.sv
package clkgen_wdog_pkg;
  localparam int unsigned MULT_W = 3;

  // Number of base ticks in one time unit for the selected scale.
  function automatic int unsigned unit_len(input logic scale,
                                           input int unsigned short_t,
                                           input int unsigned long_t);
    return scale ? long_t : short_t;
  endfunction

  // True when a multiplier code arms a real timeout.
  function automatic logic mult_arms(input logic [MULT_W-1:0] m);
    return m != '0;
  endfunction
endpackage

// File: rtl/clkgen_wdog_unit.sv
module clkgen_wdog_unit
  import clkgen_wdog_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 294,
  parameter int unsigned LONG_TICKS  = 2340
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic scale_i,
  output logic unit_end_o
);
  localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last    = (32'(cnt_q) == unit_len(scale_i, SHORT_TICKS, LONG_TICKS) - 32'd1);
  assign unit_end_o = run_i && tick_i && at_last;

  always_ff @(posedge clk) begin
    if (rst || load_i) cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < unit_len(scale_i, SHORT_TICKS, LONG_TICKS)); // R2
endmodule

// File: rtl/clkgen_wdog_count.sv
module clkgen_wdog_count
  import clkgen_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              unit_end_i,
  output logic              armed_o,
  output logic              expire_o
);
  logic [MULT_W-1:0] left_q;
  logic              armed_q;

  assign expire_o = unit_end_i && (left_q == MULT_W'(1));
  assign armed_o  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (load_i) begin
      armed_q <= mult_arms(mult_i);
      left_q  <= mult_i;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (unit_end_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == MULT_W'(1)) armed_q <= 1'b0;
    end
  end

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (left_q != '0)); // R3
  AST_HALT_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !armed_q); // R7
endmodule

// File: rtl/clkgen_wdog.sv
module clkgen_wdog
  import clkgen_wdog_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 294,
  parameter int unsigned LONG_TICKS  = 2340
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_en_i,
  input  logic [MULT_W-1:0] cfg_mult_i,
  input  logic              cfg_scale_i,
  input  logic              cfg_rst_only_i,
  input  logic              cfg_rec_src_i,
  output logic              alarm_o,
  output logic              sys_rst_o,
  output logic              freq_reload_o,
  output logic              recov_src_o
);
  logic              en_q, scale_q, ronly_q, src_q, alarm_q, pulse_q, reload_q;
  logic [MULT_W-1:0] mult_q;

  // Named internal events.
  logic load_w, stop_w, run_w, unit_end_w, expire_w, armed_w;

  assign load_w = cfg_wr_i && cfg_en_i;
  assign stop_w = cfg_wr_i && !cfg_en_i;
  assign run_w  = armed_w && !cfg_wr_i;

  clkgen_wdog_unit #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) unit_i (
    .clk(clk), .rst(rst), .load_i(load_w), .run_i(run_w),
    .tick_i(base_tick_i), .scale_i(scale_q), .unit_end_o(unit_end_w));

  clkgen_wdog_count count_i (
    .clk(clk), .rst(rst), .load_i(load_w), .stop_i(stop_w),
    .mult_i(cfg_mult_i), .unit_end_i(unit_end_w),
    .armed_o(armed_w), .expire_o(expire_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; mult_q <= '0; scale_q <= 1'b0;
      ronly_q <= 1'b0; src_q <= 1'b0;
    end else if (cfg_wr_i) begin
      en_q <= cfg_en_i; mult_q <= cfg_mult_i; scale_q <= cfg_scale_i;
      ronly_q <= cfg_rst_only_i; src_q <= cfg_rec_src_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0; pulse_q <= 1'b0; reload_q <= 1'b0;
    end else begin
      pulse_q  <= expire_w;
      reload_q <= expire_w && !ronly_q;
      if (expire_w) alarm_q <= 1'b1;
      else if (cfg_wr_i && !mult_arms(cfg_mult_i)) alarm_q <= 1'b0;
    end
  end

  assign alarm_o       = alarm_q;
  assign sys_rst_o     = pulse_q;
  assign freq_reload_o = reload_q;
  assign recov_src_o   = src_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o); // R7
  AST_RELOAD_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
    freq_reload_o |-> (sys_rst_o && !ronly_q)); // R6
  AST_ALARM_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> alarm_o); // R5
  AST_TESTMODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mult_q == '0) |-> !expire_w); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cfg_wr_i) |=> !sys_rst_o); // R4
endmodule

// File: tb/clkgen_wdog_tb_top.sv
module clkgen_wdog_tb_top;
  localparam int unsigned ST = 3;
  localparam int unsigned LT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_tick = 1'b0, cfg_wr = 1'b0, cfg_en = 1'b0;
  logic [2:0] cfg_mult = '0;
  logic cfg_scale = 1'b0, cfg_ronly = 1'b0, cfg_src = 1'b0;
  logic alarm, sys_rst, reload, rsrc;

  always #10 clk = ~clk;

  clkgen_wdog #(.SHORT_TICKS(ST), .LONG_TICKS(LT)) dut_i (
    .clk(clk), .rst(rst), .base_tick_i(base_tick), .cfg_wr_i(cfg_wr),
    .cfg_en_i(cfg_en), .cfg_mult_i(cfg_mult), .cfg_scale_i(cfg_scale),
    .cfg_rst_only_i(cfg_ronly), .cfg_rec_src_i(cfg_src),
    .alarm_o(alarm), .sys_rst_o(sys_rst), .freq_reload_o(reload), .recov_src_o(rsrc));

  typedef struct { int unsigned cyc; bit rl; } exp_t;
  exp_t sb[$];

  int unsigned cyc = 0;
  int checks = 0, errors = 0;
  bit m_armed = 0, m_alarm = 0, m_ronly = 0;
  int unsigned m_cnt = 0, m_limit = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Monitor: pop expected pulses as the design produces them.
  always @(negedge clk) begin
    if (!rst) begin
      if (sys_rst) begin
        if (sb.size() == 0) chk("R7 unexpected reset pulse", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2 pulse cycle", int'(cyc), int'(e.cyc));
          chk("R6 reload strobe", int'(reload), int'(e.rl));
        end
      end else if (reload) chk("R6 reload without reset", 1, 0);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_armed = 0; m_alarm = 0; m_cnt = 0; sb.delete();
  endtask

  task automatic wr(input bit en, input bit [2:0] m, input bit sc, input bit ro, input bit src);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en; cfg_mult = m; cfg_scale = sc; cfg_ronly = ro; cfg_src = src;
    m_ronly = ro;
    if (en) begin
      m_armed = (m != 0); m_cnt = 0; m_limit = m * (sc ? LT : ST);
    end else m_armed = 0;
    if (m == 0) m_alarm = 0;
    @(negedge clk); cfg_wr = 0;
  endtask

  // Driver: each tick pushes an expected pulse when the model predicts expiry.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1;
      if (m_armed) begin
        m_cnt++;
        if (m_cnt == m_limit) begin
          exp_t e;
          e.cyc = cyc + 1; e.rl = !m_ronly;
          sb.push_back(e);
          m_armed = 0; m_alarm = 1;
        end
      end
      @(negedge clk); base_tick = 0;
    end
  endtask

  task automatic settle(input string req);
    repeat (3) @(negedge clk);
    chk(req, sb.size(), 0);
    chk(req, int'(alarm), int'(m_alarm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 alarm", int'(alarm), 0);
    chk("R1 sys_rst", int'(sys_rst), 0);
    chk("R1 reload", int'(reload), 0);
    chk("R1 recov_src", int'(rsrc), 0);
    ticks(10);
    settle("R1 idle after reset");

    // R2/R6/R8 short base, reset+reload mode, source 1
    wr(1, 3'd2, 0, 0, 1);
    chk("R8 recov_src set", int'(rsrc), 1);
    ticks(5);
    settle("R2 no pulse one tick early");
    ticks(1);
    settle("R2 pulse at 2x short unit R5 alarm");
    // R7 no further pulses
    ticks(20);
    settle("R7 halted after timeout");
    // R5 nonzero rewrite with enable off keeps alarm
    wr(0, 3'd5, 0, 0, 1);
    settle("R5 alarm held on nonzero write");
    wr(0, 3'd0, 0, 0, 0);
    settle("R5 alarm cleared by code 000");
    chk("R8 recov_src cleared", int'(rsrc), 0);

    // R6 reset-only mode, long base
    wr(1, 3'd1, 1, 1, 0);
    ticks(LT);
    settle("R6 reset only long unit");

    // R4 servicing
    wr(0, 3'd0, 0, 0, 0);
    wr(1, 3'd3, 0, 0, 0);
    ticks(8);
    wr(1, 3'd3, 0, 0, 0);
    ticks(8);
    settle("R4 serviced no pulse");
    ticks(1);
    settle("R4 pulse after service period");

    // R4 disable
    wr(0, 3'd0, 0, 0, 0);
    wr(1, 3'd7, 0, 0, 0);
    ticks(5);
    wr(0, 3'd7, 0, 0, 0);
    ticks(30);
    settle("R4 disabled stays quiet");

    // R3 test code
    wr(1, 3'd0, 1, 0, 0);
    ticks(60);
    settle("R3 test code never fires");

    // R2 boundary: largest multiplier on long base
    wr(1, 3'd7, 1, 0, 1);
    ticks(7 * LT - 1);
    settle("R2 no pulse at 7xlong minus one");
    ticks(1);
    settle("R2 pulse at 7xlong");

    // R1 reset clears alarm and in-flight count
    wr(1, 3'd1, 0, 0, 0);
    ticks(2);
    do_reset();
    chk("R1 alarm cleared by reset", int'(alarm), 0);
    ticks(6);
    settle("R1 count dropped by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule